// File: doc/BRIEF.md
# Compact-Mode PCM Transmit Channel

This block is one transmit channel of an AC'97-style audio controller. Software, or a DMA engine outside the block, writes 32-bit words into a small FIFO. Each time the frame logic signals a new frame, the channel walks the ten PCM slots (slots 3 to 12) in ascending order. For every slot whose bit is set in a slot-enable mask, it takes the next sample. It presents one slot per clock as a number, a 20-bit value and a valid tag. The serial shifter that consumes these slot records is outside the block.

The channel has two packing modes. In normal mode each FIFO word carries one sample, taken from its low 20 bits. In compact mode a word carries two 16-bit samples: the low half is sent first, then the high half. Each half is left-aligned into the 20-bit slot. Typical masks are:

- slots 3 and 4 for stereo;
- slots 3, 4, 7 and 8 for four channels;
- slots 3, 4, 6, 7, 8 and 9 for six channels.

The channel reports these status flags:

- FIFO full;
- FIFO half-empty;
- FIFO empty;
- busy.

It raises a transmit-request interrupt while the FIFO has room for half its depth. It latches an underrun when an enabled slot finds no data. Its interrupt bits are placed in a field of a shared multi-channel status word, and a clear word removes the latched underrun.

Top module: `pcm_compact_tx`

## Requirements
- R1: The FIFO holds DEPTH (default 8) 32-bit words in arrival order; a write while the FIFO is full is dropped and leaves the contents unchanged.
- R2: `fifo_empty` is 1 exactly when the level is 0. `fifo_full` is 1 exactly when the level is DEPTH. `fifo_half_empty` is 1 exactly when the level is at most DEPTH/2. `tx_busy` is 1 while the FIFO is not empty or a frame walk is in progress. All four take their new value right after the clock edge that changes the level.
- R3: A `frame_start` sampled while idle starts a walk. On each of the next ten clock edges one slot record is registered, with `slot_vld`=1 and `slot_num` counting 3 to 12 in ascending order. `frame_start` is ignored while a walk is in progress, and `slot_vld` returns to 0 after slot 12.
- R4: Bit i of `slot_mask` enables slot i+3. Enabled slots take samples in ascending slot order, so a six-channel mask (bits 0,1,3,4,5,6) carries samples into slots 3,4,6,7,8,9. A disabled slot has `slot_tag`=0 and `slot_data`=0 and consumes nothing.
- R5: In normal mode (`compact`=0) an enabled slot with data receives bits [19:0] of the head word, `slot_tag`=1, and the word is removed.
- R6: In compact mode (`compact`=1) successive enabled slots receive bits [15:0] of the head word, then bits [31:16], each as `{half,4'h0}`. The word is removed after its high half is sent, and an unsent high half carries over into the next frame.
- R7: An enabled slot that finds the FIFO empty while the channel is enabled is sent with `slot_tag`=0 and `slot_data`=0, and sets the latched underrun flag.
- R8: The raw transmit request is `chan_en` AND `fifo_half_empty`, as a level.
- R9: `irq_word` has 7-bit fields, one per channel. This channel uses field CH_IDX, and every other field is 0. Bit 0 of the field is the transmit request AND `ie_tx`. Bit 1 is the underrun flag AND `ie_ur`. Bits 2 to 6 are 0. `irq` is the OR of `irq_word`.
- R10: A cycle with `clr_valid`=1 and `clr_bits[CH_IDX*7+1]`=1 clears the underrun flag. Any other bit of `clr_bits` has no effect.
- R11: With `chan_en`=0 a frame walk still presents all ten slots, but every slot has tag 0 and data 0. No word is consumed and no underrun is raised.
- R12: While `glob_en`=0 the FIFO is emptied, a pending compact high half is dropped, and writes and `frame_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Interface enable; low flushes the channel |
| chan_en | input | 1 | Channel transmit enable |
| compact | input | 1 | 1: two 16-bit samples per word; 0: one sample per word |
| slot_mask | input | 10 | Slot enables, bit i = slot i+3 |
| wr_valid | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| frame_start | input | 1 | Start-of-frame request |
| ie_tx | input | 1 | Transmit-request interrupt enable |
| ie_ur | input | 1 | Underrun interrupt enable |
| clr_valid | input | 1 | Interrupt clear strobe |
| clr_bits | input | 28 | Interrupt clear word |
| fifo_full | output | 1 | FIFO full |
| fifo_half_empty | output | 1 | FIFO at most half full |
| fifo_empty | output | 1 | FIFO empty |
| tx_busy | output | 1 | Data pending or frame walk in progress |
| slot_vld | output | 1 | Slot record valid this cycle |
| slot_num | output | 4 | Slot number, 3 to 12 |
| slot_tag | output | 1 | Slot carries a valid sample |
| slot_data | output | 20 | Slot sample |
| irq_word | output | 28 | Packed interrupt status for four channels |
| irq | output | 1 | Combined interrupt |

## Verification
Status flags and the transmit-request bit change at the clock edge that captures a write, so the bench reads them at the falling edge that follows. Slot records follow a fixed timing. The first record is registered one edge after the edge that accepts `frame_start`, and the remaining records follow on consecutive edges. The underrun flag is set at the same edge as the slot that caused it. The bench drives every stimulus at a falling edge and then samples each expected slot at the falling edge after its registering edge. A bench model of the FIFO contents and of the compact half pointer supplies the expected sample of every slot under sweeps of masks, modes and fill levels.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
   localparam int FIRST_PCM_SLOT = 3;
   localparam int IRQ_FIELD_W    = 7;
   localparam int IRQ_TXREQ_BIT  = 0;
   localparam int IRQ_UNDER_BIT  = 1;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;
endpackage

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
   parameter int DEPTH  = 8,
   parameter int WORD_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic [LW-1:0]     level,
   output logic              empty,
   output logic              full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pcm_tx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic              do_wr, do_rd;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_wr   = wr_en && !full && !flush;
   assign do_rd   = rd_en && !empty && !flush;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         level <= level + LW'(do_wr) - LW'(do_rd);
      end
   end

   // R1: a full FIFO with no read stays full after a write attempt
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en && !flush) |=> (full && $stable(wp)));

   // R12: the flush empties the FIFO by the next edge
   assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
   import pcm_tx_pkg::*;
#(
   parameter int NSLOT  = 10,
   parameter int WORD_W = 32,
   parameter int SLOT_W = 20,
   parameter int NUM_W  = 4,
   localparam int HALF_W = WORD_W / 2,
   localparam int KW     = $clog2(NSLOT),
   localparam int PAD    = SLOT_W - HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic              chan_en,
   input  logic              compact,
   input  logic [NSLOT-1:0]  slot_mask,
   input  logic              frame_start,
   input  logic [WORD_W-1:0] head_word,
   input  logic              fifo_empty,
   output logic              pop,
   output logic              under_evt,
   output logic              running,
   output logic              slot_vld,
   output logic [NUM_W-1:0]  slot_num,
   output logic              slot_tag,
   output logic [SLOT_W-1:0] slot_data
);
   generate
      if (SLOT_W < HALF_W || SLOT_W > WORD_W) begin : g_bad_width
         $error("pcm_slot_seq: SLOT_W must lie between WORD_W/2 and WORD_W");
      end
      if (FIRST_PCM_SLOT + NSLOT - 1 >= (1 << NUM_W) || NSLOT < 2) begin : g_bad_slots
         $error("pcm_slot_seq: slot numbers do not fit NUM_W");
      end
   endgenerate

   logic              run;
   logic [KW-1:0]     k;
   half_sel_e         hsel;
   logic              cur_en, avail, take;
   logic [HALF_W-1:0] half;
   logic [SLOT_W-1:0] cval, val;

   assign running   = run;
   assign cur_en    = run && slot_mask[k] && chan_en;
   assign avail     = !fifo_empty;
   assign take      = cur_en && avail;
   assign under_evt = cur_en && !avail;
   assign pop       = take && (!compact || hsel == HALF_HI);
   assign half      = (hsel == HALF_HI) ? head_word[WORD_W-1:HALF_W] : head_word[HALF_W-1:0];

   generate
      if (PAD == 0) begin : g_cval_exact
         assign cval = half;
      end else begin : g_cval_pad
         assign cval = {half, {PAD{1'b0}}};
      end
   endgenerate

   assign val = compact ? cval : head_word[SLOT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         k         <= '0;
         hsel      <= HALF_LO;
         slot_vld  <= 1'b0;
         slot_num  <= '0;
         slot_tag  <= 1'b0;
         slot_data <= '0;
      end else if (!glob_en) begin
         run      <= 1'b0;
         k        <= '0;
         hsel     <= HALF_LO;
         slot_vld <= 1'b0;
         slot_tag <= 1'b0;
      end else begin
         slot_vld  <= run;
         slot_tag  <= take;
         slot_data <= take ? val : '0;
         if (run) begin
            slot_num <= NUM_W'(FIRST_PCM_SLOT) + NUM_W'(k);
            if (k == KW'(NSLOT - 1)) begin
               run <= 1'b0;
               k   <= '0;
            end else begin
               k <= k + 1'b1;
            end
         end else if (frame_start) begin
            run <= 1'b1;
            k   <= '0;
         end
         if (take && compact) hsel <= (hsel == HALF_HI) ? HALF_LO : HALF_HI;
      end
   end

   // R4: a tagged sample only appears in a valid slot record
   assert_tag_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tag |-> slot_vld);

   // R3: consecutive slot records count upward by one
   assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld && $past(slot_vld)) |-> (slot_num == NUM_W'($past(slot_num) + 1'b1)));

   // R3: every walk begins at the first PCM slot
   assert_first_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_vld) |-> (slot_num == NUM_W'(FIRST_PCM_SLOT)));
endmodule

// File: rtl/pcm_tx_irq.sv
module pcm_tx_irq
   import pcm_tx_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int CH_IDX = 0,
   localparam int FW    = IRQ_FIELD_W,
   localparam int IW    = NCH * FW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_req,
   input  logic          under_evt,
   input  logic          ie_tx,
   input  logic          ie_ur,
   input  logic          clr_valid,
   input  logic [IW-1:0] clr_bits,
   output logic [IW-1:0] irq_word
);
   generate
      if (CH_IDX < 0 || CH_IDX >= NCH) begin : g_bad_idx
         $error("pcm_tx_irq: CH_IDX out of range");
      end
   endgenerate

   logic ur_flag, clr_hit;
   logic unused_clr;

   assign clr_hit    = clr_valid && clr_bits[CH_IDX*FW + IRQ_UNDER_BIT];
   assign unused_clr = ^clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ur_flag <= 1'b0;
      else if (under_evt) ur_flag <= 1'b1;
      else if (clr_hit)   ur_flag <= 1'b0;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_field
         if (c == CH_IDX) begin : g_own
            logic [FW-1:0] fld;
            always_comb begin
               fld = '0;
               fld[IRQ_TXREQ_BIT] = tx_req && ie_tx;
               fld[IRQ_UNDER_BIT] = ur_flag && ie_ur;
            end
            assign irq_word[c*FW +: FW] = fld;
         end else begin : g_other
            assign irq_word[c*FW +: FW] = '0;
         end
      end
   endgenerate

   // R7: an underrun event is latched by the next edge
   assert_under_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
      under_evt |=> ur_flag);

   // R10: the underrun flag stays until its own clear bit is written
   assert_under_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ur_flag && !clr_hit) |=> ur_flag);
endmodule

// File: rtl/pcm_compact_tx.sv
module pcm_compact_tx
   import pcm_tx_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int NSLOT  = 10,
   parameter int WORD_W = 32,
   parameter int SLOT_W = 20,
   parameter int NUM_W  = 4,
   parameter int NCH    = 4,
   parameter int CH_IDX = 0,
   localparam int LW    = $clog2(DEPTH) + 1,
   localparam int IW    = NCH * IRQ_FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic              chan_en,
   input  logic              compact,
   input  logic [NSLOT-1:0]  slot_mask,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              frame_start,
   input  logic              ie_tx,
   input  logic              ie_ur,
   input  logic              clr_valid,
   input  logic [IW-1:0]     clr_bits,
   output logic              fifo_full,
   output logic              fifo_half_empty,
   output logic              fifo_empty,
   output logic              tx_busy,
   output logic              slot_vld,
   output logic [NUM_W-1:0]  slot_num,
   output logic              slot_tag,
   output logic [SLOT_W-1:0] slot_data,
   output logic [IW-1:0]     irq_word,
   output logic              irq
);
   logic [WORD_W-1:0] head_word;
   logic [LW-1:0]     level;
   logic              pop, under_evt, running;

   pcm_tx_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(!glob_en),
      .wr_en(wr_valid), .wr_data(wr_data),
      .rd_en(pop), .rd_data(head_word),
      .level(level), .empty(fifo_empty), .full(fifo_full)
   );

   pcm_slot_seq #(.NSLOT(NSLOT), .WORD_W(WORD_W), .SLOT_W(SLOT_W), .NUM_W(NUM_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .chan_en(chan_en),
      .compact(compact), .slot_mask(slot_mask), .frame_start(frame_start),
      .head_word(head_word), .fifo_empty(fifo_empty),
      .pop(pop), .under_evt(under_evt), .running(running),
      .slot_vld(slot_vld), .slot_num(slot_num), .slot_tag(slot_tag), .slot_data(slot_data)
   );

   assign fifo_half_empty = (level <= LW'(DEPTH / 2));
   assign tx_busy         = !fifo_empty || running;

   pcm_tx_irq #(.NCH(NCH), .CH_IDX(CH_IDX)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .tx_req(chan_en && fifo_half_empty), .under_evt(under_evt),
      .ie_tx(ie_tx), .ie_ur(ie_ur),
      .clr_valid(clr_valid), .clr_bits(clr_bits),
      .irq_word(irq_word)
   );

   assign irq = |irq_word;

   // R11: a disabled channel never removes a word from the FIFO
   assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && glob_en && !wr_valid) |=> $stable(level));
endmodule

// File: tb/sim_pcm_compact_tx.sv
module sim_pcm_compact_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int NSLOT = 10;
   localparam int CHI   = 2;
   localparam int TXB   = CHI * 7;
   localparam int URB   = CHI * 7 + 1;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        glob_en = 1'b0, chan_en = 1'b0, compact = 1'b0;
   logic [9:0]  slot_mask = '0;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic        frame_start = 1'b0, ie_tx = 1'b0, ie_ur = 1'b0, clr_valid = 1'b0;
   logic [27:0] clr_bits = '0;
   logic        fifo_full, fifo_half_empty, fifo_empty, tx_busy;
   logic        slot_vld, slot_tag, irq;
   logic [3:0]  slot_num;
   logic [19:0] slot_data;
   logic [27:0] irq_word;

   pcm_compact_tx #(.DEPTH(DEPTH), .NSLOT(NSLOT), .CH_IDX(CHI)) u0 (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .chan_en(chan_en),
      .compact(compact), .slot_mask(slot_mask), .wr_valid(wr_valid),
      .wr_data(wr_data), .frame_start(frame_start), .ie_tx(ie_tx),
      .ie_ur(ie_ur), .clr_valid(clr_valid), .clr_bits(clr_bits),
      .fifo_full(fifo_full), .fifo_half_empty(fifo_half_empty),
      .fifo_empty(fifo_empty), .tx_busy(tx_busy), .slot_vld(slot_vld),
      .slot_num(slot_num), .slot_tag(slot_tag), .slot_data(slot_data),
      .irq_word(irq_word), .irq(irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [31:0] mq[$];
   bit mhalf = 0;
   bit mur = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
      if (glob_en && mq.size() < DEPTH) mq.push_back(d);
   endtask

   task automatic check_status(input string tag);
      int c;
      c = mq.size();
      chk({tag, " R2 empty"}, fifo_empty, c == 0);
      chk({tag, " R2 full"}, fifo_full, c == DEPTH);
      chk({tag, " R2 half-empty"}, fifo_half_empty, c <= DEPTH / 2);
      chk({tag, " R8/R9 tx request bit"}, irq_word[TXB], chan_en && ie_tx && (c <= DEPTH / 2));
      chk({tag, " R7/R9 underrun bit"}, irq_word[URB], mur && ie_ur);
   endtask

   task automatic run_frame(input bit restart);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      for (int k = 0; k < NSLOT; k++) begin
         bit en, etag;
         logic [19:0] edata;
         string lbl;
         @(negedge clk);
         en = slot_mask[k] && chan_en;
         etag = 1'b0;
         edata = '0;
         lbl = chan_en ? (compact ? "R6 data" : "R5 data") : "R11 data";
         if (en && mq.size() > 0) begin
            etag = 1'b1;
            if (compact) begin
               edata = mhalf ? {mq[0][31:16], 4'h0} : {mq[0][15:0], 4'h0};
               if (mhalf) void'(mq.pop_front());
               mhalf = !mhalf;
            end else begin
               edata = mq[0][19:0];
               void'(mq.pop_front());
            end
         end else if (en) begin
            mur = 1'b1;
            lbl = "R7 underrun data";
         end
         chk("R3 slot valid", slot_vld, 1);
         chk("R3 slot number", slot_num, k + 3);
         chk("R4 slot tag", slot_tag, etag);
         chk(lbl, slot_data, edata);
         if (restart) frame_start = (k == 2);
      end
      @(negedge clk);
      chk("R3 walk ends after slot 12", slot_vld, 0);
   endtask

   initial begin
      logic [9:0] masks [5];
      masks = '{10'h003, 10'h033, 10'h07B, 10'h200, 10'h007};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset empty", fifo_empty, 1);
      chk("R2 reset full", fifo_full, 0);
      chk("R2 reset half-empty", fifo_half_empty, 1);
      chk("R2 reset busy", tx_busy, 0);
      chk("R3 reset slot valid", slot_vld, 0);
      chk("R9 reset irq", irq, 0);

      glob_en = 1'b1; chan_en = 1'b1; ie_tx = 1'b1; ie_ur = 1'b1;
      @(negedge clk);
      chk("R8 request when empty", irq_word[TXB], 1);
      chk("R9 irq line", irq, 1);
      chk("R9 other fields zero", irq_word & ~(28'h3 << TXB), 0);

      // R1 fill sweep, one write past full
      for (int i = 0; i <= DEPTH; i++) begin
         push(32'hA500_0000 | 32'(i));
         check_status("R1 fill");
         chk("R2 busy", tx_busy, mq.size() != 0);
      end
      slot_mask = 10'h3FF;
      run_frame(0);
      check_status("R7 after overdrawn frame");

      // R10 clear with other bits only, then with the own bit
      clr_valid = 1'b1; clr_bits = (28'h1 << TXB) | (28'h1 << (URB + 7)) | (28'h1 << (URB - 7));
      @(negedge clk);
      clr_valid = 1'b0;
      check_status("R10 foreign clear ignored");
      clr_valid = 1'b1; clr_bits = 28'h1 << URB;
      @(negedge clk);
      clr_valid = 1'b0; mur = 1'b0;
      check_status("R10 own clear");

      // R12 flush by interface enable
      push(32'h1); push(32'h2); push(32'h3);
      check_status("R12 before flush");
      glob_en = 1'b0;
      @(negedge clk);
      mq.delete(); mhalf = 0;
      check_status("R12 flushed");
      push(32'h77);
      check_status("R12 write ignored");
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      @(negedge clk);
      chk("R12 frame ignored", slot_vld, 0);
      glob_en = 1'b1;
      @(negedge clk);

      // R4/R5 normal mode mask sweep
      for (int mi = 0; mi < 5; mi++) begin
         slot_mask = masks[mi];
         for (int j = 0; j < $countones(masks[mi]); j++)
            push(32'h9000_0000 + 32'(mi << 8) + 32'(j * 17 + 1));
         run_frame(mi == 1);
         check_status("R4 normal sweep");
      end

      // R6 compact mode mask sweep, odd counts carry a high half over
      compact = 1'b1;
      @(negedge clk);
      for (int mi = 0; mi < 5; mi++) begin
         slot_mask = masks[mi];
         for (int j = 0; j < ($countones(masks[mi]) + 1) / 2; j++)
            push({16'(16'hC000 + mi * 32 + j), 16'(16'h3000 + mi * 32 + j)});
         run_frame(0);
         check_status("R6 compact sweep");
      end
      if (mur) begin
         clr_valid = 1'b1; clr_bits = 28'h1 << URB;
         @(negedge clk);
         clr_valid = 1'b0; mur = 1'b0;
      end

      // R11 channel disabled keeps FIFO contents
      chan_en = 1'b0;
      push(32'hBEEF_1234); push(32'h5678_CAFE);
      slot_mask = 10'h3FF;
      run_frame(0);
      check_status("R11 disabled channel");
      chk("R11 busy with data held", tx_busy, 1);
      chan_en = 1'b1;
      @(negedge clk);
      run_frame(0);
      check_status("R7 compact underrun");
      chk("R2 idle busy", tx_busy, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R3: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule